// File: doc/BRIEF.md
# Summed-Word Gaussian Noise Source

This block makes a stream of signed 16-bit noise samples for a DAC. The samples have an approximately Gaussian distribution. A 32-bit maximal-length shift register is the random source. On every accepted sample it moves sixteen places, so each sample receives a fresh, non-overlapping 16-bit word. These words are uniformly distributed, and they are read as signed two's complement so that their mean is zero.

A boxcar sum over the fifteen most recent words shapes the distribution toward a bell curve. The sum is kept incrementally: the newest word is added and the word leaving a 15-deep history is subtracted. An unsigned fixed-point gain then scales the sum, and the result is clamped to the signed 16-bit range.

At the nominal gain of 183 (Q4.12), the RMS output is about one tenth of positive full scale. The worst-case peak stays inside the code range, so the crest factor is bounded. The user strobes `smp_stb` at the DAC update rate. The user may reseed the source at any time, and takes `noise_q` once `noise_ok` is high.

Top module: `gauss_noise_gen`

## Requirements
- R1: The word used by an accepted sample is the low 16 bits of the 32-bit generator state, read as signed. The state is then advanced by sixteen single-bit shifts. Each shift moves the state left by one and inserts at bit 0 the XOR of state bits 31, 21, 1 and 0 (feedback mask 0x80200003).
- R2: While `rst_n` is low, `noise_q` is 0 and `noise_ok` is 0. Reset sets the generator state to 0xACE12468 and clears the history and the sum.
- R3: When `seed_ld` is high at a clock edge, the generator state takes `seed_val`, or 0xACE12468 if `seed_val` is zero. No sample is taken at that edge, even if `smp_stb` is also high. The state is never zero.
- R4: The sum equals the total of the last fifteen accepted words, with equal weight on each. Before fifteen samples have been accepted, the missing entries count as zero.
- R5: `noise_ok` rises one clock after the edge that accepts the fifteenth sample since reset, and it then stays high until the next reset.
- R6: On every clock, `noise_q` is registered as the sum multiplied by the unsigned Q4.12 value of `gain_in`, then shifted right arithmetically by 12. The result therefore appears one clock after the sum and gain it was computed from.
- R7: A scaled value above 32767 gives 32767, and a value below -32768 gives -32768. The output never wraps.
- R8: A clock edge with `smp_stb` and `seed_ld` both low leaves the generator state and the sum unchanged, so the output changes only if `gain_in` changes.
- R9: The accumulator holds the full range of fifteen signed 16-bit words (±491520) without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Take one sample on this edge |
| seed_ld | input | 1 | Load `seed_val` into the generator (wins over `smp_stb`) |
| seed_val | input | 32 | Seed value; zero is replaced by 0xACE12468 |
| gain_in | input | 16 | Unsigned Q4.12 output gain |
| noise_q | output | 16 | Signed noise sample |
| noise_ok | output | 1 | High once the history is full |

## Verification
A wrong generator state or a bad feedback tap changes the word taken at the next strobe. Because the output is recomputed every clock, the sample total is off one clock after that strobe. A history that drops or repeats an entry only becomes visible fifteen samples later, when the stale word should leave the sum. The output is therefore compared with an independent model on every clock for long runs. A low gain keeps accumulator width faults from being hidden by the clamp, and a high gain exposes faults in the clamp itself.

// File: rtl/gn_pkg.sv
package gn_pkg;
  localparam int          GN_LFSR_W   = 32;
  localparam int          GN_WORD_W   = 16;
  localparam logic [31:0] GN_TAP_MASK = 32'h8020_0003;
  localparam logic [31:0] GN_SEED_DEF = 32'hACE1_2468;
  localparam int          GN_TAPS     = 15;
  localparam int          GN_GAIN_W   = 16;
  localparam int          GN_FRAC     = 12;
  localparam int          GN_GAIN_NOM = 183;

  // Bits needed to sum n signed words of width w without overflow.
  function automatic int sum_width(input int w, input int n);
    return w + $clog2(n);
  endfunction
endpackage

// File: rtl/gn_lfsr_words.sv
module gn_lfsr_words #(
  parameter int          LFSR_W   = 32,
  parameter int          WORD_W   = 16,
  parameter logic [31:0] TAP_MASK = 32'h8020_0003,
  parameter logic [31:0] SEED_DEF = 32'hACE1_2468
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv_i,
  input  logic                     load_i,
  input  logic [LFSR_W-1:0]        seed_i,
  output logic signed [WORD_W-1:0] word_o
);
  localparam logic [LFSR_W-1:0] MASK = TAP_MASK[LFSR_W-1:0];
  localparam logic [LFSR_W-1:0] DEFS = SEED_DEF[LFSR_W-1:0];

  // Advance by WORD_W single-bit shifts so consecutive words do not overlap.
  function automatic logic [LFSR_W-1:0] jump(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int i = 0; i < WORD_W; i++) t = {t[LFSR_W-2:0], ^(t & MASK)};
    return t;
  endfunction

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] seed_eff;
  logic              seed_zero;

  assign seed_zero = (seed_i == '0);
  assign seed_eff  = seed_zero ? DEFS : seed_i;
  assign word_o    = $signed(state_q[WORD_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= DEFS;
    else if (load_i) state_q <= seed_eff;
    else if (adv_i)  state_q <= jump(state_q);
  end

  assert_state_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  assert_zero_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && seed_zero |=> state_q == DEFS);
  assert_hold_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i && !load_i |=> $stable(state_q));
endmodule

// File: rtl/gn_boxcar.sv
module gn_boxcar #(
  parameter int WORD_W = 16,
  parameter int TAPS   = 15,
  parameter int ACC_W  = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push_i,
  input  logic signed [WORD_W-1:0] word_i,
  output logic signed [ACC_W-1:0] sum_o,
  output logic                    full_o
);
  localparam int CNT_W = $clog2(TAPS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TAPS);

  logic signed [WORD_W-1:0] hist_q [TAPS];
  logic signed [ACC_W-1:0]  acc_q;
  logic [CNT_W-1:0]         cnt_q;
  logic signed [ACC_W-1:0]  add_x, sub_x;

  assign add_x = {{(ACC_W-WORD_W){word_i[WORD_W-1]}}, word_i};
  assign sub_x = {{(ACC_W-WORD_W){hist_q[TAPS-1][WORD_W-1]}}, hist_q[TAPS-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hist_q[0] <= '0;
    else if (push_i) hist_q[0] <= word_i;
  end

  for (genvar g = 1; g < TAPS; g++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hist_q[g] <= '0;
      else if (push_i) hist_q[g] <= hist_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      acc_q <= acc_q + add_x - sub_x;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sum_o  = acc_q;
  assign full_o = (cnt_q == CNT_MAX);

  localparam logic signed [ACC_W-1:0] BOUND = ACC_W'(TAPS * (2 ** (WORD_W-1)));
  assert_acc_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= BOUND) && (acc_q >= -BOUND));
  assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && cnt_q == CNT_MAX - 1'b1 |=> full_o);
  assert_full_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |=> full_o);
  assert_sum_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !push_i |=> $stable(acc_q));
endmodule

// File: rtl/gn_gain_clip.sv
module gn_gain_clip #(
  parameter int ACC_W  = 20,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 12,
  parameter int OUT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ACC_W-1:0] sum_i,
  input  logic [GAIN_W-1:0]       gain_i,
  input  logic                    ok_i,
  output logic signed [OUT_W-1:0] q_o,
  output logic                    ok_o
);
  localparam int PROD_W = ACC_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] HI =
    {{(PROD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] LO = ~HI;
  localparam logic signed [OUT_W-1:0] OHI = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OLO = {1'b1, {(OUT_W-1){1'b0}}};

  function automatic logic signed [PROD_W-1:0] scale(
    input logic signed [ACC_W-1:0] s, input logic [GAIN_W-1:0] g);
    logic signed [PROD_W-1:0] p;
    p = {{(GAIN_W+1){s[ACC_W-1]}}, s} * $signed({{ACC_W{1'b0}}, 1'b0, g});
    return p >>> FRAC;
  endfunction

  logic signed [PROD_W-1:0] scaled;
  logic                     clip_hi, clip_lo;
  logic signed [OUT_W-1:0]  clamped;

  assign scaled  = scale(sum_i, gain_i);
  assign clip_hi = scaled > HI;
  assign clip_lo = scaled < LO;
  always_comb begin
    if (clip_hi)      clamped = OHI;
    else if (clip_lo) clamped = OLO;
    else              clamped = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o  <= '0;
      ok_o <= 1'b0;
    end else begin
      q_o  <= clamped;
      ok_o <= ok_i;
    end
  end

  assert_clip_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clip_hi |=> q_o == OHI);
  assert_clip_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clip_lo |=> q_o == OLO);
  assert_zero_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gain_i == '0 |=> q_o == '0);
endmodule

// File: rtl/gauss_noise_gen.sv
module gauss_noise_gen #(
  parameter int          LFSR_W    = gn_pkg::GN_LFSR_W,
  parameter int          WORD_W    = gn_pkg::GN_WORD_W,
  parameter logic [31:0] TAP_MASK  = gn_pkg::GN_TAP_MASK,
  parameter logic [31:0] SEED_DEF  = gn_pkg::GN_SEED_DEF,
  parameter int          TAPS      = gn_pkg::GN_TAPS,
  parameter int          GAIN_W    = gn_pkg::GN_GAIN_W,
  parameter int          FRAC      = gn_pkg::GN_FRAC,
  parameter int          OUT_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_stb,
  input  logic                    seed_ld,
  input  logic [LFSR_W-1:0]       seed_val,
  input  logic [GAIN_W-1:0]       gain_in,
  output logic signed [OUT_W-1:0] noise_q,
  output logic                    noise_ok
);
  localparam int ACC_W = gn_pkg::sum_width(WORD_W, TAPS);

  logic                    take_smp;
  logic signed [WORD_W-1:0] word_w;
  logic signed [ACC_W-1:0]  sum_w;
  logic                     full_w;

  // A seed load claims the edge; no sample is taken with it.
  assign take_smp = smp_stb && !seed_ld;

  gn_lfsr_words #(.LFSR_W(LFSR_W), .WORD_W(WORD_W), .TAP_MASK(TAP_MASK),
                  .SEED_DEF(SEED_DEF)) u_src (
    .clk(clk), .rst_n(rst_n), .adv_i(take_smp), .load_i(seed_ld),
    .seed_i(seed_val), .word_o(word_w));

  gn_boxcar #(.WORD_W(WORD_W), .TAPS(TAPS), .ACC_W(ACC_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .push_i(take_smp), .word_i(word_w),
    .sum_o(sum_w), .full_o(full_w));

  gn_gain_clip #(.ACC_W(ACC_W), .GAIN_W(GAIN_W), .FRAC(FRAC), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .sum_i(sum_w), .gain_i(gain_in), .ok_i(full_w),
    .q_o(noise_q), .ok_o(noise_ok));

  assert_ok_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    noise_ok |=> noise_ok);
  assert_seed_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ld && smp_stb |=> $stable(sum_w));
endmodule

// File: tb/gauss_noise_gen_tb_top.sv
module gauss_noise_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0, seed_ld = 1'b0;
  logic [31:0] seed_val = '0;
  logic [15:0] gain_in = 16'd183;
  logic signed [15:0] noise_q;
  logic noise_ok;

  always #2 clk = ~clk;

  gauss_noise_gen dut_i (.clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .seed_ld(seed_ld), .seed_val(seed_val), .gain_in(gain_in),
    .noise_q(noise_q), .noise_ok(noise_ok));

  int n_chk = 0, n_bad = 0;
  int unsigned m_st;
  int m_q[$];
  longint m_sum;
  int m_out;
  bit m_ok;
  string tag;
  int unsigned lcg = 32'h1357_9bdf;
  int hi_hits = 0, lo_hits = 0;

  function automatic int unsigned step16(input int unsigned s);
    for (int k = 0; k < 16; k++) s = (s << 1) | int'($countones(s & 32'h8020_0003) % 2);
    return s;
  endfunction

  function automatic int clip(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic model_reset();
    m_st = 32'hACE1_2468; m_q.delete(); m_sum = 0; m_out = 0; m_ok = 0;
  endtask

  task automatic model_edge();
    m_out = clip((m_sum * longint'(gain_in)) >>> 12);
    m_ok  = (m_q.size() == 15);
    if (seed_ld) m_st = (seed_val == 0) ? 32'hACE1_2468 : seed_val;
    else if (smp_stb) begin
      m_q.push_front(int'($signed(m_st[15:0])));
      if (m_q.size() > 15) void'(m_q.pop_back());
      m_sum = 0;
      foreach (m_q[k]) m_sum += m_q[k];
      m_st = step16(m_st);
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit se, input bit sl, input logic [31:0] sd);
    smp_stb = se; seed_ld = sl; seed_val = sd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R6 R4 R1", int'(noise_q), m_out);
    check("R5", int'(noise_ok), int'(m_ok));
    if (noise_q == 16'sd32767) hi_hits++;
    if (noise_q == -16'sd32768) lo_hits++;
  endtask

  function automatic bit coin(input int pct);
    lcg = lcg * 1664525 + 1013904223;
    return (lcg >> 8) % 100 < pct;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hold_v;
    model_reset();
    tag = "reset R2";
    repeat (3) @(negedge clk);
    check("R2", int'(noise_q), 0);
    check("R2", int'(noise_ok), 0);
    rst_n = 1'b1;

    tag = "nominal fill R1 R4 R5";
    for (int i = 0; i < 40; i++) cyc(1, 0, 0);

    tag = "sparse strobes and gain steps R8";
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) gain_in = 16'(100 + i * 7);
      cyc(coin(40), 0, 0);
    end

    tag = "hold R8";
    gain_in = 16'd183;
    cyc(0, 0, 0);
    hold_v = int'(noise_q);
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, 0);
      check("R8", int'(noise_q), hold_v);
    end

    tag = "seed load R3";
    cyc(0, 1, 32'h1234_5678);
    for (int i = 0; i < 60; i++) cyc(1, 0, 0);
    tag = "zero seed with strobe R3";
    cyc(1, 1, 32'h0);
    for (int i = 0; i < 60; i++) cyc(1, 0, 0);

    tag = "low gain accumulator R9";
    gain_in = 16'd1;
    for (int i = 0; i < 1500; i++) cyc(1, 0, 0);

    tag = "high gain clamp R7";
    gain_in = 16'hFFFF;
    for (int i = 0; i < 2000; i++) cyc(coin(80), 0, 0);
    tag = "clamp reached R7";
    check("R7", int'(hi_hits > 0), 1);
    check("R7", int'(lo_hits > 0), 1);

    tag = "reset mid-run R2 R5";
    gain_in = 16'd183;
    @(negedge clk); rst_n = 1'b0; model_reset();
    @(negedge clk);
    check("R2", int'(noise_ok), 0);
    check("R2", int'(noise_q), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 14; i++) cyc(1, 0, 0);
    cyc(0, 0, 0);
    check("R5", int'(noise_ok), 0);
    cyc(1, 0, 0);
    cyc(0, 0, 0);
    check("R5", int'(noise_ok), 1);
    for (int i = 0; i < 300; i++) cyc(coin(60), coin(2), lcg);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule